// File: doc/BRIEF.md
# Locked Read-Modify-Write Counter Incrementer

This block adds one to a counter word held in shared memory. A packet classifier, or any other engine that keeps statistics in a table, hands it a word address with a one-clock request. The block then reads that word over a Wishbone classic master port, adds one to the value it read, and writes the sum back to the same address. All of this happens inside a single bus cycle. The cycle line is held high from the read strobe until the operation ends, so an arbiter cannot hand the memory to a CPU or a second engine between the read and the write. No update is lost or torn.

The value is always fetched fresh from memory. The block keeps no copy of any earlier value. The sum wraps from all ones to zero. If the bus signals an error on either the read or the write, the operation stops, the cycle line is released and the block reports an error together with its completion pulse. The adder is built from carry-chained chunks whose width is a parameter. Its result is registered in a separate modify state, so the width of the adder never lands on the bus timing path.

Top module: `atomic_ctr_inc`

## Requirements
- R1: While reset is asserted and after it is released with no request, wb_cyc_o, wb_stb_o, wb_we_o, done_o and err_o are all low.
- R2: A request sampled while idle starts a read on the next clock: wb_cyc_o and wb_stb_o high, wb_we_o low, wb_adr_o equal to the requested address.
- R3: The write data equals the value returned by the read plus one, modulo 2^DATA_W. Carries cross chunk boundaries, and all ones becomes zero.
- R4: After the read is acknowledged there is one modify clock with wb_stb_o low. Then a write strobe (wb_we_o high) is issued to the same address.
- R5: wb_cyc_o stays high without a gap from the read strobe until the clock after done_o, then drops. wb_stb_o is never high without wb_cyc_o.
- R6: done_o is high for exactly one clock, the clock after the acknowledge of the write.
- R7: An error on the read phase leads, on the next clock, to done_o and err_o high. No write strobe is issued and the memory word is unchanged.
- R8: An error on the write phase leads, on the next clock, to done_o and err_o high.
- R9: A request that arrives while an operation is in progress is ignored: it starts no operation and touches no memory word.
- R10: When another master increments the same word whenever wb_cyc_o is low, the final value equals the initial value plus all increments from both masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an increment (sampled only while idle) |
| req_addr_i | input | ADDR_W | Word address of the counter |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Valid with done_o: operation aborted by a bus error |
| wb_cyc_o | output | 1 | Bus cycle, held through the whole operation |
| wb_stb_o | output | 1 | Strobe for the read and the write phases |
| wb_we_o | output | 1 | High during the write phase |
| wb_adr_o | output | ADDR_W | Word address on the bus |
| wb_dat_o | output | DATA_W | Incremented value for the write |
| wb_dat_i | input | DATA_W | Read data from memory |
| wb_ack_i | input | 1 | Phase acknowledge |
| wb_err_i | input | 1 | Phase error |

## Verification
The assertions assume a well-behaved slave. It raises wb_ack_i or wb_err_i only while wb_stb_o is high, it never raises both at once, and it holds each for exactly one clock. The bench memory model keeps to this. It answers a strobe one clock after it sees it, masks a new answer while its previous one is still showing, and returns an error instead of an acknowledge only for two reserved addresses: one faults on the read and the other on the write. The competing master in the bench acts only on clocks where the cycle line is low, which is the arbitration rule the block depends on.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_MODIFY = 3'd2,
      ST_WRITE  = 3'd3,
      ST_DONE   = 3'd4
   } inc_state_t;

endpackage

// File: rtl/ctr_inc_seq.sv
module ctr_inc_seq
   import ctr_inc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_i,
   input  logic       ack_i,
   input  logic       err_i,
   output inc_state_t state_o,
   output logic       fault_o
);

   inc_state_t state_q, state_d;
   logic       fault_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_i) state_d = ST_READ;
         ST_READ:   if (err_i) state_d = ST_DONE;
                    else if (ack_i) state_d = ST_MODIFY;
         ST_MODIFY: state_d = ST_WRITE;
         ST_WRITE:  if (err_i || ack_i) state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_DONE)
            fault_q <= 1'b0;
         else if ((state_q == ST_READ || state_q == ST_WRITE) && err_i)
            fault_q <= 1'b1;
      end
   end

   assign state_o = state_q;
   assign fault_o = fault_q;

   // R6: completion is followed by a return to idle
   a_r6_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_DONE |=> state_q == ST_IDLE);

   // R4: the modify clock always leads into the write phase
   a_r4_modify_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_MODIFY |=> state_q == ST_WRITE);

endmodule

// File: rtl/ctr_inc_dp.sv
module ctr_inc_dp #(
   parameter int ADDR_W  = 30,
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] rdat_i,
   input  logic              bump_i,
   output logic [ADDR_W-1:0] adr_o,
   output logic [DATA_W-1:0] wdat_o
);

   localparam int NCHUNK = DATA_W / CHUNK_W;

   logic [ADDR_W-1:0] adr_q;
   logic [DATA_W-1:0] val_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] inc_w;
   logic [NCHUNK:0]   carry_w;

   if (DATA_W % CHUNK_W != 0) begin : g_bad_chunk
      $error("ctr_inc_dp: DATA_W must be a multiple of CHUNK_W");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ctr_inc_dp: widths must be positive");
   end

   assign carry_w[0] = 1'b1;

   if (NCHUNK == 1) begin : g_flat
      assign inc_w      = val_q + DATA_W'(1);
      assign carry_w[1] = &val_q;
   end else begin : g_chain
      for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
         logic [CHUNK_W:0] part_w;
         assign part_w = {1'b0, val_q[g*CHUNK_W +: CHUNK_W]} + {{CHUNK_W{1'b0}}, carry_w[g]};
         assign inc_w[g*CHUNK_W +: CHUNK_W] = part_w[CHUNK_W-1:0];
         assign carry_w[g+1] = part_w[CHUNK_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         adr_q  <= '0;
         val_q  <= '0;
         wdat_q <= '0;
      end else begin
         if (load_i) adr_q  <= addr_i;
         if (cap_i)  val_q  <= rdat_i;
         if (bump_i) wdat_q <= inc_w;
      end
   end

   assign adr_o  = adr_q;
   assign wdat_o = wdat_q;

   // R3: the registered sum is the captured read value plus one, wrapping
   a_r3_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bump_i |=> wdat_o == $past(val_q) + DATA_W'(1));

   // R3: captured read data comes straight from the bus
   a_r3_fresh_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i |=> val_q == $past(rdat_i));

endmodule

// File: rtl/atomic_ctr_inc.sv
module atomic_ctr_inc
   import ctr_inc_pkg::*;
#(
   parameter int ADDR_W  = 30,
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              done_o,
   output logic              err_o,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   output logic              wb_we_o,
   output logic [ADDR_W-1:0] wb_adr_o,
   output logic [DATA_W-1:0] wb_dat_o,
   input  logic [DATA_W-1:0] wb_dat_i,
   input  logic              wb_ack_i,
   input  logic              wb_err_i
);

   inc_state_t state_w;
   logic       fault_w;
   logic       load_w, cap_w, bump_w;

   ctr_inc_seq u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .ack_i   (wb_ack_i),
      .err_i   (wb_err_i),
      .state_o (state_w),
      .fault_o (fault_w)
   );

   assign load_w = (state_w == ST_IDLE) && req_i;
   assign cap_w  = (state_w == ST_READ) && wb_ack_i && !wb_err_i;
   assign bump_w = (state_w == ST_MODIFY);

   ctr_inc_dp #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CHUNK_W (CHUNK_W)
   ) u_dp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_w),
      .addr_i (req_addr_i),
      .cap_i  (cap_w),
      .rdat_i (wb_dat_i),
      .bump_i (bump_w),
      .adr_o  (wb_adr_o),
      .wdat_o (wb_dat_o)
   );

   assign wb_cyc_o = (state_w != ST_IDLE);
   assign wb_stb_o = (state_w == ST_READ) || (state_w == ST_WRITE);
   assign wb_we_o  = (state_w == ST_WRITE);
   assign done_o   = (state_w == ST_DONE);
   assign err_o    = (state_w == ST_DONE) && fault_w;

   // R5: no strobe outside a bus cycle
   a_r5_stb_in_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_stb_o |-> wb_cyc_o);

   // R5: the cycle line is only released right after completion
   a_r5_cyc_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wb_cyc_o) |-> $past(done_o));

   // R6: single-clock completion pulse
   a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R6: a write acknowledge completes the operation on the next clock
   a_r6_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_stb_o && wb_we_o && wb_ack_i && !wb_err_i) |=> (done_o && !err_o));

   // R2: a request while idle opens with a read strobe
   a_r2_start_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wb_cyc_o && req_i) |=> (wb_stb_o && !wb_we_o && wb_adr_o == $past(req_addr_i)));

   // R4: the address holds across the whole locked cycle
   a_r4_adr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && $past(wb_cyc_o)) |-> $stable(wb_adr_o));

   // R7: a read error aborts without a write
   a_r7_read_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_stb_o && !wb_we_o && wb_err_i) |=> (done_o && err_o && !wb_stb_o));

   // R8: a write error aborts with an error report
   a_r8_write_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_stb_o && wb_we_o && wb_err_i) |=> (done_o && err_o));

   // R9: a request during an operation changes nothing on the bus address
   a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && req_i) |=> $stable(wb_adr_o));

endmodule

// File: tb/atomic_ctr_inc_tb_top.sv
module atomic_ctr_inc_tb_top;

   localparam int AW = 30;
   localparam int DW = 32;
   localparam logic [3:0] RD_FAULT = 4'd14;
   localparam logic [3:0] WR_FAULT = 4'd15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          done, err, cyc, stb, we;
   logic [AW-1:0] adr;
   logic [DW-1:0] dat_o, rdata;
   logic          ack, berr;

   always #4 clk = ~clk;

   atomic_ctr_inc #(.ADDR_W(AW), .DATA_W(DW), .CHUNK_W(8)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
      .done_o(done), .err_o(err), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we),
      .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(rdata), .wb_ack_i(ack), .wb_err_i(berr)
   );

   integer tests = 0;
   integer fails = 0;
   integer cycles = 0;

   logic [DW-1:0] mem [16];
   logic [DW-1:0] expv [16];
   integer        stage = 0;
   logic [AW-1:0] ref_addr = '0;
   logic          comp_en = 1'b0;
   logic [3:0]    comp_idx = 4'd0;
   integer        comp_n = 0;
   logic [DW-1:0] old_val = '0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // memory slave, competing master and the cycle reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; berr <= 1'b0; rdata <= '0;
         for (int i = 0; i < 16; i++) begin
            mem[i]  <= DW'(i * 100);
            expv[i] = DW'(i * 100);
         end
         mem[5] <= '1;            expv[5] = '1;
         mem[6] <= 32'h0000_FFFF; expv[6] = 32'h0000_FFFF;
         stage = 0;
      end else begin
         ack <= 1'b0; berr <= 1'b0;
         if (cyc && stb && !ack && !berr) begin
            if (adr[3:0] == RD_FAULT) berr <= 1'b1;
            else if (we && adr[3:0] == WR_FAULT) berr <= 1'b1;
            else begin
               ack <= 1'b1;
               if (we) mem[adr[3:0]] <= dat_o;
               else    rdata <= mem[adr[3:0]];
            end
         end
         if (comp_en && !cyc) begin
            mem[comp_idx] <= mem[comp_idx] + 1;
            expv[comp_idx] = expv[comp_idx] + 1;
            comp_n++;
         end
         case (stage)
            0: if (req) begin stage = 1; ref_addr = req_addr; end
            1: stage = 2;
            2: stage = (ref_addr[3:0] == RD_FAULT) ? 6 : 3;
            3: stage = 4;
            4: stage = 5;
            5: stage = 6;
            default: begin
               if (ref_addr[3:0] != RD_FAULT && ref_addr[3:0] != WR_FAULT)
                  expv[ref_addr[3:0]] = expv[ref_addr[3:0]] + 1;
               stage = 0;
            end
         endcase
      end
   end

   // per-clock comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_cyc, e_stb, e_we, e_done, e_err;
         e_cyc  = (stage != 0);
         e_stb  = (stage == 1 || stage == 2 || stage == 4 || stage == 5);
         e_we   = (stage == 4 || stage == 5);
         e_done = (stage == 6);
         e_err  = (stage == 6) && (ref_addr[3:0] == RD_FAULT || ref_addr[3:0] == WR_FAULT);
         check(cyc == e_cyc, "R5 cyc", 64'(cyc), 64'(e_cyc));
         check(stb == e_stb, "R2/R4 stb", 64'(stb), 64'(e_stb));
         check(we == e_we, "R4 we", 64'(we), 64'(e_we));
         check(done == e_done, "R6 done", 64'(done), 64'(e_done));
         check(err == e_err, "R7/R8 err", 64'(err), 64'(e_err));
         if (e_cyc) check(adr == ref_addr, "R4 adr", 64'(adr), 64'(ref_addr));
         if (stage == 2) old_val = rdata;
         if (stage == 4) check(dat_o == old_val + 1, "R3 write data", 64'(dat_o), 64'(old_val + 1));
      end
   end

   task automatic do_inc(input logic [AW-1:0] a, input bit poke_busy);
      @(negedge clk); req = 1'b1; req_addr = a;
      @(negedge clk); req = 1'b0;
      if (poke_busy) begin
         @(negedge clk);
         @(negedge clk); req = 1'b1; req_addr = AW'(7);
         @(negedge clk); req = 1'b0;
      end
      repeat (8) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] start3;
      repeat (3) @(negedge clk);
      // R1: idle outputs during reset
      check({cyc, stb, we, done, err} == 5'b0, "R1 reset outputs", 64'({cyc, stb, we, done, err}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({cyc, stb, we, done, err} == 5'b0, "R1 after reset", 64'({cyc, stb, we, done, err}), 64'd0);

      do_inc(AW'(2), 1'b0);
      check(mem[2] == 32'd201, "R2 plain increment", 64'(mem[2]), 64'd201);
      do_inc(AW'(6), 1'b0);
      check(mem[6] == 32'h0001_0000, "R3 carry across chunks", 64'(mem[6]), 64'h10000);
      do_inc(AW'(5), 1'b0);
      check(mem[5] == 32'd0, "R3 wrap to zero", 64'(mem[5]), 64'd0);
      do_inc(AW'(14), 1'b0);
      check(mem[14] == 32'd1400, "R7 read fault leaves word", 64'(mem[14]), 64'd1400);
      do_inc(AW'(15), 1'b0);
      check(mem[15] == 32'd1500, "R8 write fault leaves word", 64'(mem[15]), 64'd1500);
      do_inc(AW'(1), 1'b1);
      check(mem[7] == 32'd700, "R9 busy request ignored", 64'(mem[7]), 64'd700);
      check(mem[1] == 32'd101, "R9 running op completes", 64'(mem[1]), 64'd101);

      // R10: contention with a master that increments whenever the cycle is free
      start3 = mem[3];
      comp_n = 0;
      comp_idx = 4'd3;
      comp_en = 1'b1;
      for (int k = 0; k < 10; k++) do_inc(AW'(3), 1'b0);
      @(negedge clk); comp_en = 1'b0;
      repeat (2) @(negedge clk);
      check(mem[3] == start3 + DW'(10) + DW'(comp_n), "R10 no lost increments",
            64'(mem[3]), 64'(start3 + DW'(10) + DW'(comp_n)));
      for (int i = 0; i < 16; i++)
         check(mem[i] == expv[i], "R10 final memory image", 64'(mem[i]), 64'(expv[i]));

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule